// File: doc/BRIEF.md
# Adaptive RC5 Infrared Frame Decoder

This block turns the output of a demodulating infrared receiver into RC5 commands. The receiver pin is active low: it idles high and is pulled low while the carrier is present. A frame is 14 Manchester-coded bits. The decoder arms on the first falling edge of the line, which is the mid-bit edge of the first start bit. After that it walks the remaining 13 bit positions, sampling each one a quarter of a bit period into the bit.

The decoder does not rely on a fixed bit period. Each Manchester mid-bit edge it observes restarts its interval timer, and the elapsed time becomes the period estimate for the next bit. This lets it follow a transmitter whose clock is off nominal or drifts during the frame. A mid-bit edge must arrive before a deadline. If it does not, the frame is dropped as truncated and a one-cycle error strobe is raised. A completed frame produces a 7-bit command and a 5-bit address. The valid strobe is withheld when the toggle bit shows that the frame repeats the last key press.

Top module: `rc5_rx_decoder`

## Requirements
- R1: While reset is asserted and right after it is released, `valid_o` and `err_o` are low and `cmd_o` and `addr_o` are zero.
- R2: While idle, a falling edge on `ir_n_i` starts a frame. This edge is the reference, and the period estimate is set to `BIT_NOM` ticks. A tick is `TICK_DIV` clock cycles.
- R3: At three quarters of the current period estimate after each reference edge, the synchronized line level is sampled as one data bit, with high meaning 1. The 13 samples arrive in the order S2, toggle, A4..A0, C5..C0, and are shifted in most-significant first.
- R4: On a completed frame, `addr_o` carries A4..A0. `cmd_o[5:0]` carries C5..C0, and `cmd_o[6]` is the inverse of the S2 sample.
- R5: Every line edge seen after a sample and before the deadline is taken as the mid-bit edge. The elapsed tick count becomes the new period estimate, and the timer restarts from zero, so frames whose bit period drifts steadily decode correctly.
- R6: If no edge follows a sample within five quarters of the period estimate, counted from the reference edge, the frame is dropped. `err_o` pulses for exactly one cycle, and `valid_o` stays low.
- R7: A frame whose toggle bit equals the toggle of the last completed frame is a repeat and gives no `valid_o`. Every completed frame stores its toggle, including repeats. Dropped frames do not store their toggle, and the first frame after reset is never a repeat.
- R8: `valid_o` is a single-cycle pulse that never coincides with `err_o`. `cmd_o` and `addr_o` change only in a cycle where `valid_o` is high.
- R9: Falling edges that occur inside a frame (bit boundaries between zeros, for example) never restart decoding.
- R10: A frame completes when the mid-bit edge of its last bit is seen. After completion or abort the decoder is idle and accepts the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ir_n_i | input | 1 | Demodulated receiver output, active low, asynchronous |
| cmd_o | output | 7 | Command C6..C0 of the last fresh frame |
| addr_o | output | 5 | Address A4..A0 of the last fresh frame |
| valid_o | output | 1 | One-cycle strobe for a new, non-repeated frame |
| err_o | output | 1 | One-cycle strobe for a truncated frame |

## Verification
On every cycle, the assertions check the following:
- the strobes are single-cycle and mutually exclusive;
- the outputs hold between valid strobes;
- a repeat or an abort never produces a valid strobe;
- the interval timer never passes the abort deadline while an edge is awaited;
- the timer restarts on each mid-bit edge;
- the decoder is idle whenever it reports an outcome.

Some behaviours only the bench scenarios can show. These are the correct bit order and S2 inversion, tracking of slow and fast drifting bit periods, immunity to boundary falling edges, and the toggle history across a dropped frame.

// File: rtl/rc5_pkg.sv
package rc5_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SAMPLE = 2'd1,
    ST_EDGE   = 2'd2
  } rc5_state_e;

  // Tick count after a reference edge at which the next bit is sampled:
  // half a period to the bit boundary plus a quarter into the bit.
  function automatic logic [31:0] sample_mark(input logic [31:0] per);
    return (per >> 1) + (per >> 2);
  endfunction

  // Deadline for the mid-bit edge: the sample point plus another half.
  function automatic logic [31:0] abort_mark(input logic [31:0] per);
    return sample_mark(per) + (per >> 1);
  endfunction

endpackage

// File: rtl/rc5_sync_edge.sv
module rc5_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic level_o,
  output logic fall_o,
  output logic edge_o
);

  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  if (STAGES == 1) begin : g_single
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '1;
      else        sync_q <= pin_i;
    end
  end else begin : g_chain
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '1;
      else        sync_q <= {sync_q[STAGES-2:0], pin_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= sync_q[STAGES-1];
  end

  assign level_o = sync_q[STAGES-1];
  assign fall_o  = prev_q & ~level_o;
  assign edge_o  = prev_q ^ level_o;

endmodule

// File: rtl/rc5_bit_timer.sv
module rc5_bit_timer #(
  parameter int TICK_DIV = 1,
  parameter int CNT_W    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  output logic [CNT_W-1:0] count_o
);

  logic tick;

  if (TICK_DIV == 1) begin : g_nodiv
    assign tick = 1'b1;
  end else begin : g_div
    localparam int DIV_W = $clog2(TICK_DIV);
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(TICK_DIV - 1);
    logic [DIV_W-1:0] pre_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                pre_q <= '0;
      else if (clear_i)          pre_q <= '0;
      else if (pre_q == DIV_LAST) pre_q <= '0;
      else                       pre_q <= pre_q + 1'b1;
    end
    assign tick = (pre_q == DIV_LAST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      count_o <= '0;
    else if (clear_i)                count_o <= '0;
    else if (tick && count_o != '1)  count_o <= count_o + 1'b1;
  end

  // R5: the count only holds or steps by one unless cleared
  p_count_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_i |=> (count_o == $past(count_o)) || (count_o == $past(count_o) + 1'b1));

endmodule

// File: rtl/rc5_frame_fsm.sv
module rc5_frame_fsm #(
  parameter int CNT_W      = 16,
  parameter int BIT_NOM    = 1778,
  parameter int FRAME_BITS = 14
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  level_i,
  input  logic                  fall_i,
  input  logic                  edge_i,
  input  logic [CNT_W-1:0]      cnt_i,
  output logic                  timer_clear_o,
  output logic                  done_o,
  output logic                  abort_o,
  output logic [FRAME_BITS-2:0] word_o
);
  import rc5_pkg::*;

  localparam int DATA_BITS = FRAME_BITS - 1;
  localparam int IDX_W     = $clog2(DATA_BITS + 1);
  localparam logic [IDX_W-1:0] IDX_FULL = IDX_W'(DATA_BITS);

  rc5_state_e            state_q;
  logic [CNT_W-1:0]      period_q;
  logic [DATA_BITS-1:0]  shreg_q;
  logic [IDX_W-1:0]      nbit_q;
  logic                  done_q;
  logic                  abort_q;

  logic cnt_ge_samp, cnt_ge_abort;
  logic start_evt, samp_evt, mid_evt, late_evt, all_taken;

  assign cnt_ge_samp  = (32'(cnt_i) >= sample_mark(32'(period_q)));
  assign cnt_ge_abort = (32'(cnt_i) >= abort_mark(32'(period_q)));
  assign all_taken    = (nbit_q == IDX_FULL);

  assign start_evt = (state_q == ST_IDLE)   && fall_i;
  assign samp_evt  = (state_q == ST_SAMPLE) && cnt_ge_samp;
  assign mid_evt   = (state_q == ST_EDGE)   && edge_i;
  assign late_evt  = (state_q == ST_EDGE)   && !edge_i && cnt_ge_abort;

  assign timer_clear_o = (state_q == ST_IDLE) || mid_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      period_q <= CNT_W'(BIT_NOM);
      shreg_q  <= '0;
      nbit_q   <= '0;
      done_q   <= 1'b0;
      abort_q  <= 1'b0;
    end else begin
      done_q  <= mid_evt && all_taken;
      abort_q <= late_evt;
      unique case (state_q)
        ST_IDLE: begin
          if (start_evt) begin
            state_q  <= ST_SAMPLE;
            period_q <= CNT_W'(BIT_NOM);
            shreg_q  <= '0;
            nbit_q   <= '0;
          end
        end
        ST_SAMPLE: begin
          if (samp_evt) begin
            shreg_q <= {shreg_q[DATA_BITS-2:0], level_i};
            nbit_q  <= nbit_q + 1'b1;
            state_q <= ST_EDGE;
          end
        end
        ST_EDGE: begin
          if (mid_evt) begin
            period_q <= cnt_i;
            state_q  <= all_taken ? ST_IDLE : ST_SAMPLE;
          end else if (late_evt) begin
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign done_o  = done_q;
  assign abort_o = abort_q;
  assign word_o  = shreg_q;

  // R6: while an edge is awaited the timer never runs past the deadline
  p_deadline_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_EDGE) |-> (32'(cnt_i) <= abort_mark(32'(period_q))));
  // R5: a mid-bit edge restarts the interval timer
  p_restart_on_mid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mid_evt |=> (cnt_i == '0));
  // R10: an outcome is only reported once the decoder is idle again
  p_idle_after_outcome_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q || abort_q) |-> (state_q == ST_IDLE));
  // R3: never more samples than data bits
  p_sample_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |-> (nbit_q <= IDX_FULL));
  // R9: a falling edge mid-frame does not send the decoder back to idle
  p_no_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_SAMPLE) && fall_i) |=> (state_q != ST_IDLE));

endmodule

// File: rtl/rc5_rx_decoder.sv
module rc5_rx_decoder #(
  parameter int TICK_DIV    = 1,
  parameter int BIT_NOM     = 1778,
  parameter int CNT_W       = 16,
  parameter int FRAME_BITS  = 14,
  parameter int ADDR_W      = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         ir_n_i,
  output logic [FRAME_BITS-ADDR_W-3:0] cmd_o,
  output logic [ADDR_W-1:0]            addr_o,
  output logic                         valid_o,
  output logic                         err_o
);

  localparam int DATA_BITS = FRAME_BITS - 1;
  localparam int CLO_W     = DATA_BITS - 2 - ADDR_W;

  logic                 lvl_w, fall_w, edge_w;
  logic                 clr_w, done_w, abort_w;
  logic [CNT_W-1:0]     cnt_w;
  logic [DATA_BITS-1:0] word_w;

  rc5_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(ir_n_i),
    .level_o(lvl_w), .fall_o(fall_w), .edge_o(edge_w)
  );

  rc5_bit_timer #(.TICK_DIV(TICK_DIV), .CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .clear_i(clr_w), .count_o(cnt_w)
  );

  rc5_frame_fsm #(.CNT_W(CNT_W), .BIT_NOM(BIT_NOM), .FRAME_BITS(FRAME_BITS)) u_fsm (
    .clk(clk), .rst_n(rst_n), .level_i(lvl_w), .fall_i(fall_w), .edge_i(edge_w),
    .cnt_i(cnt_w), .timer_clear_o(clr_w), .done_o(done_w), .abort_o(abort_w),
    .word_o(word_w)
  );

  logic              s2_w, tog_w, rep_hit_w;
  logic [ADDR_W-1:0] addr_w;
  logic [CLO_W-1:0]  clo_w;
  logic              tog_q, tog_known_q;

  assign s2_w      = word_w[DATA_BITS-1];
  assign tog_w     = word_w[DATA_BITS-2];
  assign addr_w    = word_w[DATA_BITS-3 -: ADDR_W];
  assign clo_w     = word_w[CLO_W-1:0];
  assign rep_hit_w = tog_known_q && (tog_w == tog_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tog_q       <= 1'b0;
      tog_known_q <= 1'b0;
      cmd_o       <= '0;
      addr_o      <= '0;
      valid_o     <= 1'b0;
      err_o       <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      err_o   <= abort_w;
      if (done_w) begin
        tog_q       <= tog_w;
        tog_known_q <= 1'b1;
        if (!rep_hit_w) begin
          cmd_o   <= {~s2_w, clo_w};
          addr_o  <= addr_w;
          valid_o <= 1'b1;
        end
      end
    end
  end

  // R8: strobes never coincide
  p_strobe_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(valid_o && err_o));
  // R8: valid lasts one cycle
  p_valid_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);
  // R6: error lasts one cycle
  p_err_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> !err_o);
  // R8: outputs hold outside a valid strobe
  p_hold_outputs_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> ($stable(cmd_o) && $stable(addr_o)));
  // R7: a repeated frame yields no valid strobe
  p_repeat_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_w && rep_hit_w) |=> !valid_o);
  // R6: an aborted frame yields no valid strobe
  p_abort_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
    abort_w |=> !valid_o);

endmodule

// File: tb/rc5_rx_decoder_bench.sv
module rc5_rx_decoder_bench;

  localparam int DIV = 2;
  localparam int NOM = 80;  // ticks per bit -> 80 cycles per half bit

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ir_n = 1'b1;
  logic [6:0] cmd_o;
  logic [4:0] addr_o;
  logic       valid_o, err_o;

  always #5 clk = ~clk;

  rc5_rx_decoder #(.TICK_DIV(DIV), .BIT_NOM(NOM)) u_rc5_rx_decoder (
    .clk(clk), .rst_n(rst_n), .ir_n_i(ir_n),
    .cmd_o(cmd_o), .addr_o(addr_o), .valid_o(valid_o), .err_o(err_o)
  );

  typedef struct packed {
    logic       is_err;
    logic [6:0] cmd;
    logic [4:0] addr;
  } ev_t;

  ev_t        evq[$];
  int         total = 0;
  int         bad = 0;
  logic [6:0] m_cmd = '0;
  logic [4:0] m_addr = '0;
  logic       m_tog = 1'b0;
  bit         m_known = 0;
  bit         prev_valid = 0;
  bit         finished = 0;
  int         cyc = 0;

  task automatic check(input string req, input string what, input int act, input int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // Reference model of the outcome of one frame, from the requirements.
  task automatic expect_frame(input logic s2, input logic t, input logic [4:0] a,
                              input logic [5:0] c, input bit truncated);
    ev_t e;
    if (truncated) begin
      e.is_err = 1'b1; e.cmd = '0; e.addr = '0;
      evq.push_back(e);
    end else begin
      if (!(m_known && t == m_tog)) begin
        e.is_err = 1'b0;
        e.cmd    = 7'((s2 ? 0 : 64) + int'(c));
        e.addr   = a;
        evq.push_back(e);
      end
      m_tog = t; m_known = 1;
    end
  endtask

  // Active-low Manchester: a 1 bit is high then low, a 0 bit low then high.
  task automatic send_frame(input logic s2, input logic t, input logic [4:0] a,
                            input logic [5:0] c, input int h0, input int step,
                            input int nbits);
    logic [13:0] b;
    int h;
    b = {1'b1, s2, t, a, c};
    h = h0;
    for (int k = 13; k >= 14 - nbits; k--) begin
      ir_n = b[k];
      repeat (h) @(negedge clk);
      ir_n = ~b[k];
      repeat (h) @(negedge clk);
      h = h + step;
    end
  endtask

  task automatic run_frame(input string req, input logic s2, input logic t,
                           input logic [4:0] a, input logic [5:0] c,
                           input int h0, input int step);
    expect_frame(s2, t, a, c, 0);
    send_frame(s2, t, a, c, h0, step, 14);
    ir_n = 1'b1;
    repeat (300) @(negedge clk);
    check(req, "pending outcomes", evq.size(), 0);
  endtask

  // Monitor: compare outputs against the model on every clock.
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (valid_o && err_o) check("R8", "strobes together", 1, 0);
      if (valid_o && prev_valid) check("R8", "valid longer than one cycle", 2, 1);
      if (valid_o || err_o) begin
        if (evq.size() == 0) begin
          check("R7", "unexpected strobe valid/err", {valid_o, err_o}, 0);
        end else begin
          ev_t e;
          e = evq.pop_front();
          check(e.is_err ? "R6" : "R3", "strobe kind err", int'(err_o), int'(e.is_err));
          if (!e.is_err) begin
            check("R4", "cmd", int'(cmd_o), int'(e.cmd));
            check("R4", "addr", int'(addr_o), int'(e.addr));
            m_cmd = e.cmd; m_addr = e.addr;
          end
        end
      end
      check("R8", "cmd held", int'(cmd_o), int'(m_cmd));
      check("R8", "addr held", int'(addr_o), int'(m_addr));
      prev_valid = valid_o;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !finished) begin
      finished = 1;
      bad++; total++;
      $display("FAIL R10 watchdog actual=%0d expected=finish", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "valid in reset", int'(valid_o), 0);
    check("R1", "err in reset", int'(err_o), 0);
    check("R1", "cmd in reset", int'(cmd_o), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R1", "addr after reset", int'(addr_o), 0);
    check("R1", "valid after reset", int'(valid_o), 0);

    // R2 R3 R4: nominal frame, first after reset (never a repeat, R7)
    run_frame("R2", 1'b1, 1'b0, 5'h05, 6'h0C, 80, 0);
    // R7: same toggle -> repeat, no strobe, outputs held
    run_frame("R7", 1'b1, 1'b0, 5'h12, 6'h21, 80, 0);
    // R4: S2 low sets command bit 6
    run_frame("R4", 1'b0, 1'b1, 5'h1F, 6'h3F, 80, 0);
    // R9: all-zero fields put falling edges on bit boundaries
    run_frame("R9", 1'b1, 1'b0, 5'h00, 6'h00, 80, 0);
    // R6: truncated after 7 bits -> error, toggle not stored
    expect_frame(1'b1, 1'b1, 5'h0A, 6'h15, 1);
    send_frame(1'b1, 1'b1, 5'h0A, 6'h15, 80, 0, 7);
    repeat (500) @(negedge clk);
    ir_n = 1'b1;
    repeat (100) @(negedge clk);
    check("R6", "pending after truncation", evq.size(), 0);
    // R10 R7: toggle 1 is fresh because the dropped frame was not stored
    run_frame("R10", 1'b1, 1'b1, 5'h0A, 6'h15, 80, 0);
    // R5: bit period stretching every bit
    run_frame("R5", 1'b1, 1'b0, 5'h15, 6'h2A, 80, 3);
    // R5: constant fast transmitter
    run_frame("R5", 1'b0, 1'b1, 5'h0E, 6'h31, 68, 0);
    // R5: bit period shrinking every bit
    run_frame("R5", 1'b1, 1'b0, 5'h11, 6'h07, 80, -2);
    // R7: repeat after the drift frame
    run_frame("R7", 1'b0, 1'b0, 5'h03, 6'h1B, 80, 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule